// File: doc/BRIEF.md
# Channel Flag Bit-Clear Command Bank

This block holds three per-channel flag arrays for a 64-channel transfer controller: an error-interrupt enable array, an interrupt request array and an error flag array. Channel engines raise bits through one-cycle set pulses. Software lowers them through byte-wide command registers. Each command byte names one channel whose bit is to be cleared. It can also clear the whole array, or it can ask for nothing to be done.

The command bytes sit in adjacent byte lanes. One 32-bit bus write can therefore issue several commands, and each enabled lane is decoded on its own. All enabled lanes take effect on the same clock edge. Each array can be read back as a high word and a low word. Writes to the enable array's readback words set bits, so software can load a known state.

The bus is a single-cycle register interface. A write is accepted on the rising edge at which `req_i` and `we_i` are both high. A read returns data combinationally while `req_i` is high and `we_i` is low.

Top module: `chan_flag_clr`

## Requirements
- R1: After an asynchronous reset, all bits of the enable, request and error arrays are 0.
- R2: Command bytes are mapped in big-endian lanes. Byte 0x1B is bits 7:0 of word 0x18 and clears the enable array. Byte 0x1C is bits 31:24 of word 0x1C and clears the request array. Byte 0x1D is bits 23:16 of word 0x1C and clears the error array. Bytes 0x18–0x1A and 0x1E–0x1F have no effect.
- R3: A command byte with bit 7 = 0 and value n in 0..63 clears only bit n of its array, where bit n belongs to channel n. The change is visible after the edge that accepts the write.
- R4: A command byte with bit 7 = 0 and a value of 64..127 (bit 6 = 1) clears every bit of its array.
- R5: A command byte with bit 7 = 1 changes nothing, whatever its low seven bits hold.
- R6: Several command lanes in one word write are all applied on the same edge.
- R7: A lane whose byte enable is 0 has no effect. With no set pulse and no command, every array holds its value.
- R8: A set pulse on bit n sets that bit on the next edge. When a set and a clear hit the same bit in one cycle, the bit ends up set.
- R9: Reads of words 0x18 and 0x1C return 0.
- R10: Reads return these array halves: 0x40 enable[63:32], 0x44 enable[31:0], 0x48 request[63:32], 0x4C request[31:0], 0x50 error[63:32], 0x54 error[31:0]. All other addresses read 0, and `rdata_o` is 0 when no read is requested.
- R11: A write to 0x40 or 0x44 ORs each enabled lane into the matching enable bits. It never clears a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address, word aligned |
| be_i | input | 4 | Byte enables, be_i[j] covers wdata_i[8j+7:8j] |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| een_set_i | input | 64 | Hardware set pulses, enable array |
| irq_set_i | input | 64 | Hardware set pulses, request array |
| err_set_i | input | 64 | Hardware set pulses, error array |
| een_o | output | 64 | Error-interrupt enable array |
| irq_o | output | 64 | Interrupt request array |
| err_o | output | 64 | Error flag array |

## Verification
The hardest case to reach is a set pulse and a clear command landing on the same bit in the same cycle, especially when the clear is a global one. The bench drives the set vector and the command write together in directed steps for both the single-bit and the global form. A long random phase then overlaps sparse set pulses with multi-lane command words, no-op bytes and partial byte enables. A behavioural model checks all three arrays and the read data on every clock.

// File: rtl/chan_flag_clr_pkg.sv
package chan_flag_clr_pkg;
  localparam int N_TGT = 3;
  // byte offset of each clear command: enable, request, error
  localparam logic [7:0] CMD_OFF [N_TGT] = '{8'h1B, 8'h1C, 8'h1D};
  localparam logic [7:0] RD_EEN_HI = 8'h40;
  localparam logic [7:0] RD_EEN_LO = 8'h44;
  localparam logic [7:0] RD_IRQ_HI = 8'h48;
  localparam logic [7:0] RD_IRQ_LO = 8'h4C;
  localparam logic [7:0] RD_ERR_HI = 8'h50;
  localparam logic [7:0] RD_ERR_LO = 8'h54;

  function automatic logic [7:0] word_of(logic [7:0] off);
    return {off[7:2], 2'b00};
  endfunction

  // big-endian lane: offset 0 within word is the top byte
  function automatic int lane_of(logic [7:0] off);
    return 3 - int'(off[1:0]);
  endfunction
endpackage

// File: rtl/chan_cmd_decode.sv
module chan_cmd_decode #(
  parameter int N_CH = 64
) (
  input  logic            en_i,
  input  logic [7:0]      cmd_i,
  output logic [N_CH-1:0] mask_o
);
  always_comb begin
    mask_o = '0;
    if (en_i && !cmd_i[7]) begin
      if (cmd_i[6]) begin
        mask_o = '1;
      end else begin
        for (int i = 0; i < N_CH; i++) begin
          if (cmd_i[5:0] == 6'(i)) mask_o[i] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/chan_flag_reg.sv
module chan_flag_reg #(
  parameter int N_CH = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] set_i,
  input  logic [N_CH-1:0] clr_i,
  output logic [N_CH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;
  end

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  a_r3_clear_applied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));

  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/chan_flag_clr.sv
module chan_flag_clr
  import chan_flag_clr_pkg::*;
#(
  parameter int N_CH   = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [N_CH-1:0]   een_set_i,
  input  logic [N_CH-1:0]   irq_set_i,
  input  logic [N_CH-1:0]   err_set_i,
  output logic [N_CH-1:0]   een_o,
  output logic [N_CH-1:0]   irq_o,
  output logic [N_CH-1:0]   err_o
);
  localparam int PAD_W = 64;

  logic            wr;
  logic [N_CH-1:0] hw_set [N_TGT];
  logic [N_CH-1:0] q      [N_TGT];
  logic [N_CH-1:0] sw_set;
  logic [PAD_W-1:0] sw_set_w;
  logic [PAD_W-1:0] een_w, irq_w, err_w;

  assign wr = req_i && we_i;
  assign hw_set[0] = een_set_i;
  assign hw_set[1] = irq_set_i;
  assign hw_set[2] = err_set_i;

  // direct writes to the enable readback words OR in bits
  always_comb begin
    sw_set_w = '0;
    if (wr) begin
      for (int j = 0; j < 4; j++) begin
        if (be_i[j]) begin
          if (addr_i == ADDR_W'(RD_EEN_HI)) sw_set_w[32+8*j +: 8] = wdata_i[8*j +: 8];
          if (addr_i == ADDR_W'(RD_EEN_LO)) sw_set_w[8*j +: 8]    = wdata_i[8*j +: 8];
        end
      end
    end
  end
  assign sw_set = sw_set_w[N_CH-1:0];

  for (genvar k = 0; k < N_TGT; k++) begin : g_tgt
    localparam logic [7:0] WORD = word_of(CMD_OFF[k]);
    localparam int         LANE = lane_of(CMD_OFF[k]);
    logic            hit;
    logic [N_CH-1:0] clr;
    logic [N_CH-1:0] set;

    assign hit = wr && (addr_i == ADDR_W'(WORD)) && be_i[LANE];

    chan_cmd_decode #(.N_CH(N_CH)) u_dec (
      .en_i  (hit),
      .cmd_i (wdata_i[8*LANE +: 8]),
      .mask_o(clr)
    );

    if (k == 0) begin : g_sw
      assign set = hw_set[k] | sw_set;
    end else begin : g_hw
      assign set = hw_set[k];
    end

    chan_flag_reg #(.N_CH(N_CH)) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set),
      .clr_i (clr),
      .q_o   (q[k])
    );
  end

  assign een_o = q[0];
  assign irq_o = q[1];
  assign err_o = q[2];

  assign een_w = PAD_W'(q[0]);
  assign irq_w = PAD_W'(q[1]);
  assign err_w = PAD_W'(q[2]);

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      case (addr_i)
        ADDR_W'(RD_EEN_HI): rdata_o = een_w[63:32];
        ADDR_W'(RD_EEN_LO): rdata_o = een_w[31:0];
        ADDR_W'(RD_IRQ_HI): rdata_o = irq_w[63:32];
        ADDR_W'(RD_IRQ_LO): rdata_o = irq_w[31:0];
        ADDR_W'(RD_ERR_HI): rdata_o = err_w[63:32];
        ADDR_W'(RD_ERR_LO): rdata_o = err_w[31:0];
        default:            rdata_o = '0;
      endcase
    end
  end

  a_r9_cmd_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (addr_i == ADDR_W'(8'h18) || addr_i == ADDR_W'(8'h1C))) |-> (rdata_o == '0));

  a_r10_idle_rdata_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || we_i) |-> (rdata_o == '0));

  // R4: global request clear leaves only bits set in the same cycle
  a_r4_global_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(8'h1C) && be_i[3] && wdata_i[31:30] == 2'b01)
      |=> (irq_o == $past(irq_set_i)));

  a_r5_nop_keeps_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_set_i == '0 && !(wr && addr_i == ADDR_W'(8'h1C) && be_i[2] && !wdata_i[23]))
      |=> $stable(err_o));
endmodule

// File: tb/chan_flag_clr_tb.sv
module chan_flag_clr_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] een_set_i = '0, irq_set_i = '0, err_set_i = '0;
  logic [63:0] een_o, irq_o, err_o;

  int total = 0, bad = 0;
  bit done = 0;
  string cur = "R1";
  logic [63:0] m_een, m_irq, m_err;

  always #5 clk_i = ~clk_i;

  chan_flag_clr u_dut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .be_i, .wdata_i, .rdata_o,
    .een_set_i, .irq_set_i, .err_set_i, .een_o, .irq_o, .err_o
  );

  // behavioural reference
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_een <= '0; m_irq <= '0; m_err <= '0;
    end else begin
      logic [63:0] c0, c1, c2, s0;
      c0 = '0; c1 = '0; c2 = '0; s0 = een_set_i;
      if (req_i && we_i) begin
        for (int ln = 0; ln < 4; ln++) begin
          if (be_i[ln]) begin
            logic [7:0] b;
            int off;
            b = wdata_i[8*ln +: 8];
            off = int'(addr_i) + (3 - ln);
            if (addr_i == 8'h40) s0[32+8*ln +: 8] = s0[32+8*ln +: 8] | b;
            else if (addr_i == 8'h44) s0[8*ln +: 8] = s0[8*ln +: 8] | b;
            else if (b < 8'd128) begin
              logic [63:0] m;
              m = (b >= 8'd64) ? '1 : (64'd1 << b);
              if (off == 'h1B) c0 = c0 | m;
              else if (off == 'h1C) c1 = c1 | m;
              else if (off == 'h1D) c2 = c2 | m;
            end
          end
        end
      end
      m_een <= (m_een & ~c0) | s0;
      m_irq <= (m_irq & ~c1) | irq_set_i;
      m_err <= (m_err & ~c2) | err_set_i;
    end
  end

  function automatic logic [31:0] m_read();
    if (!req_i || we_i) return '0;
    case (addr_i)
      8'h40: return m_een[63:32];
      8'h44: return m_een[31:0];
      8'h48: return m_irq[63:32];
      8'h4C: return m_irq[31:0];
      8'h50: return m_err[63:32];
      8'h54: return m_err[31:0];
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk({cur, " een"}, een_o, m_een);
      chk({cur, " irq"}, irq_o, m_irq);
      chk({cur, " err"}, err_o, m_err);
      chk({cur, " rdata"}, 64'(rdata_o), 64'(m_read()));
    end
  end

  task automatic step();
    @(posedge clk_i); #2;
  endtask

  task automatic idle();
    req_i = 0; we_i = 0; addr_i = '0; be_i = '0; wdata_i = '0;
    een_set_i = '0; irq_set_i = '0; err_set_i = '0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] b);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d; be_i = b;
    step(); idle();
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
    req_i = 1; we_i = 0; addr_i = a; #1;
    chk(tag, 64'(rdata_o), 64'(exp));
    step(); idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1;
    step();
    chk("R1 een", een_o, '0); chk("R1 irq", irq_o, '0); chk("R1 err", err_o, '0);

    cur = "R11";
    wr(8'h40, 32'hFFFF_FFFF, 4'hF);
    wr(8'h44, 32'hFFFF_FFFF, 4'hF);
    chk("R11 load", een_o, '1);

    cur = "R8";
    irq_set_i = '1; err_set_i = '1; step(); idle();
    chk("R8 irq set", irq_o, '1); chk("R8 err set", err_o, '1);

    cur = "R3";
    wr(8'h18, 32'h0000_0005, 4'b0001);
    chk("R3 ch5", een_o, ~(64'd1 << 5));
    wr(8'h18, 32'h0000_0028, 4'b0001);
    chk("R3 ch40", een_o, ~((64'd1 << 5) | (64'd1 << 40)));

    cur = "R5";
    wr(8'h18, 32'h0000_0085, 4'b0001);
    wr(8'h18, 32'h0000_00C0, 4'b0001);
    chk("R5 nop", een_o, ~((64'd1 << 5) | (64'd1 << 40)));

    cur = "R2";
    wr(8'h18, 32'h4001_0203, 4'b1110);
    chk("R2 dead lanes", een_o, ~((64'd1 << 5) | (64'd1 << 40)));

    cur = "R7";
    wr(8'h18, 32'h0000_0009, 4'b0000);
    wr(8'h1C, 32'h4040_4040, 4'b0011);
    chk("R7 een", een_o, ~((64'd1 << 5) | (64'd1 << 40)));
    chk("R7 irq", irq_o, '1);

    cur = "R6";
    wr(8'h1C, {8'd3, 8'd63, 8'd1, 8'd2}, 4'b1111);
    chk("R6 irq", irq_o, ~(64'd1 << 3));
    chk("R6 err", err_o, ~(64'd1 << 63));

    cur = "R8";
    irq_set_i = 64'd1 << 7;
    req_i = 1; we_i = 1; addr_i = 8'h1C; be_i = 4'b1000; wdata_i = {8'd7, 24'h0};
    step(); idle();
    chk("R8 set beats clear", irq_o, ~(64'd1 << 3));

    cur = "R4";
    wr(8'h1C, {8'd64, 8'h7F, 16'h0}, 4'b1100);
    chk("R4 irq", irq_o, '0); chk("R4 err", err_o, '0);
    err_set_i = 64'd1 << 9;
    req_i = 1; we_i = 1; addr_i = 8'h1C; be_i = 4'b0100; wdata_i = {8'h0, 8'd100, 16'h0};
    step(); idle();
    chk("R8 set beats global", err_o, 64'd1 << 9);

    cur = "R9";
    rd("R9 word18", 8'h18, 32'h0);
    rd("R9 word1C", 8'h1C, 32'h0);

    cur = "R10";
    rd("R10 een hi", 8'h40, 32'hFFFF_FEFF);
    rd("R10 een lo", 8'h44, 32'hFFFF_FFDF);
    rd("R10 irq hi", 8'h48, 32'h0);
    rd("R10 err lo", 8'h54, 32'h0000_0200);
    rd("R10 unmapped", 8'h60, 32'h0);

    cur = "R11";
    wr(8'h40, 32'h0000_0000, 4'hF);
    wr(8'h44, 32'h0000_0020, 4'b0001);
    chk("R11 or only", een_o, ~(64'd1 << 40));

    cur = "random";
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = $urandom_range(0, 7);
      req_i = ($urandom_range(0, 3) != 0);
      we_i = $urandom_range(0, 1);
      be_i = 4'($urandom);
      wdata_i = $urandom;
      case (sel)
        0, 1: addr_i = 8'h18;
        2, 3: addr_i = 8'h1C;
        4: addr_i = 8'h40;
        5: addr_i = 8'h44;
        default: addr_i = 8'h40 + 8'($urandom_range(0, 7) * 4);
      endcase
      if ($urandom_range(0, 5) == 0) irq_set_i = 64'd1 << $urandom_range(0, 63);
      if ($urandom_range(0, 5) == 0) err_set_i = 64'd1 << $urandom_range(0, 63);
      if ($urandom_range(0, 9) == 0) een_set_i = 64'd1 << $urandom_range(0, 63);
      step();
      idle();
    end

    step();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule